// File: doc/BRIEF.md
# Unicast/Multicast Equal-Priority Tie-Breaker

When a unicast cell and a multicast cell of the same priority both want the same output port, this block picks the winner. Software programs a 16-bit fairness register that holds two 8-bit masks. One mask covers output ports 16 to 31 and the other covers ports 0 to 15. A free-running 3-bit pseudo-random index picks one bit of the mask that applies. The unicast cell wins when that bit is 1. Over every run of eight contended decisions, each index value appears exactly once, so a mask with x bits set gives unicast exactly x wins in 8.

When only one cell type requests the port, that cell is granted and the masks have no effect. Each decision is registered and appears one cycle after its request. The register is read and written byte by byte through a small host port.

Top module: `ucmc_tiebreak`

## Requirements
- R1: After reset, the lower mask byte reads 0xA3, the upper mask byte reads 0x3A, `grant_valid_o` and `grant_uc_o` are 0, and the next contended decision uses index 1.
- R2: When `host_we_i` is 1, host address 0x9 writes the lower mask byte (ports 0–15) and 0xA writes the upper mask byte (ports 16–31). A write changes only the byte it addresses. A write to any other address changes neither byte.
- R3: `host_rdata_o` is combinational. It returns the lower byte at address 0x9, the upper byte at 0xA, and 0x00 at every other address.
- R4: A port number of 16 or more selects the upper byte. A port number of 15 or less selects the lower byte.
- R5: On a contended request (`req_valid_i` and `both_i` both 1), `grant_uc_o` equals bit `idx` of the selected mask, where `idx` is the current 3-bit index (bit 0 is the LSB).
- R6: The index steps through 1, 2, 5, 3, 7, 6, 4, 0 and then repeats. It advances by one step after each contended request and holds in every other cycle.
- R7: On a request with `both_i` = 0, `grant_uc_o` equals `is_uc_i`, whatever the masks hold.
- R8: `grant_valid_o` is 1 in the cycle after a cycle with `req_valid_i` = 1, and 0 otherwise. `grant_uc_o` is 0 whenever `grant_valid_o` is 0.
- R9: Over any 8 consecutive contended requests to the same half, unicast wins exactly popcount(mask) times. An all-zero mask means multicast always wins, and an all-one mask means unicast always wins.
- R10: A contended request uses the mask value held before the clock edge, even when a host write to that byte happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Arbitration request for one output port this cycle |
| port_i | input | 5 | Target output port number |
| both_i | input | 1 | Both a unicast and a multicast cell contend |
| is_uc_i | input | 1 | When `both_i` is 0: 1 = the sole requester is unicast |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 4 | Host register address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data (combinational) |
| grant_valid_o | output | 1 | A decision is present this cycle |
| grant_uc_o | output | 1 | 1 = unicast granted, 0 = multicast granted |

## Verification
The assertions assume that `both_i` and `is_uc_i` mean something only while `req_valid_i` is high, and that `port_i` is stable and in range during a request. The bench drives every input on the falling edge. It only raises `both_i` or `is_uc_i` together with `req_valid_i`, and otherwise ties them low. Random stimulus mixes idle cycles, single-type requests, contended requests to both halves, and host writes aimed at valid and invalid addresses, including writes in the same cycle as a request.

// File: rtl/ucmc_pkg.sv
package ucmc_pkg;
  localparam int unsigned MASK_W  = 8;
  localparam int unsigned HOST_AW = 4;
  localparam logic [HOST_AW-1:0] ADDR_LO = 4'h9;
  localparam logic [HOST_AW-1:0] ADDR_HI = 4'hA;
  localparam logic [MASK_W-1:0]  RST_LO  = 8'hA3;
  localparam logic [MASK_W-1:0]  RST_HI  = 8'h3A;

  typedef logic [MASK_W-1:0] mask_t;
endpackage

// File: rtl/ucmc_fair_regs.sv
module ucmc_fair_regs
  import ucmc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  mask_t              wdata_i,
  output mask_t              rdata_o,
  output mask_t              mask_lo_o,
  output mask_t              mask_hi_o
);
  mask_t lo_q, hi_q;
  logic  wr_lo, wr_hi;

  assign wr_lo = we_i && (addr_i == ADDR_LO);
  assign wr_hi = we_i && (addr_i == ADDR_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= RST_LO;
      hi_q <= RST_HI;
    end else begin
      if (wr_lo) lo_q <= wdata_i;
      if (wr_hi) hi_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_LO: rdata_o = lo_q;
      ADDR_HI: rdata_o = hi_q;
      default: rdata_o = '0;
    endcase
  end

  assign mask_lo_o = lo_q;
  assign mask_hi_o = hi_q;

  p_lo_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_LO) |=> $stable(mask_lo_o));
  p_hi_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_HI) |=> $stable(mask_hi_o));
  p_lo_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_LO) |=> mask_lo_o == $past(wdata_i));
endmodule

// File: rtl/ucmc_idx_gen.sv
module ucmc_idx_gen #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] s_q, s_d;

  generate
    if (IDX_W == 3) begin : g_debruijn
      // x^3+x^2+1 with the all-zero state spliced in: period 8
      logic fb;
      assign fb   = s_q[2] ^ s_q[1] ^ ~|s_q[1:0];
      assign s_d  = {s_q[1:0], fb};
    end else begin : g_count
      assign s_d = s_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    s_q <= IDX_W'(1);
    else if (adv_i) s_q <= s_d;
  end

  assign idx_o = s_q;

  p_idx_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(idx_o));
  p_idx_move_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> idx_o != $past(idx_o));
endmodule

// File: rtl/ucmc_decide.sv
module ucmc_decide
  import ucmc_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 32,
  parameter int unsigned PORT_W    = $clog2(NUM_PORTS),
  parameter int unsigned IDX_W     = $clog2(MASK_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              both_i,
  input  logic              is_uc_i,
  input  logic [PORT_W-1:0] port_i,
  input  mask_t             mask_lo_i,
  input  mask_t             mask_hi_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              adv_o,
  output logic              grant_valid_o,
  output logic              grant_uc_o
);
  localparam logic [PORT_W-1:0] HALF = PORT_W'(NUM_PORTS / 2);

  logic  upper_half;
  mask_t sel_mask;
  logic  uc_win;
  logic  gv_q, guc_q;

  assign upper_half = (port_i >= HALF);
  assign sel_mask   = upper_half ? mask_hi_i : mask_lo_i;
  assign adv_o      = req_valid_i && both_i;
  assign uc_win     = both_i ? sel_mask[idx_i] : is_uc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gv_q  <= 1'b0;
      guc_q <= 1'b0;
    end else begin
      gv_q  <= req_valid_i;
      guc_q <= req_valid_i && uc_win;
    end
  end

  assign grant_valid_o = gv_q;
  assign grant_uc_o    = guc_q;

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> grant_valid_o);
  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !grant_valid_o && !grant_uc_o);
  p_sole_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !both_i) |=> grant_uc_o == $past(is_uc_i));
  p_mc_always_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && sel_mask == '0) |=> !grant_uc_o);
  p_uc_always_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && &sel_mask) |=> grant_uc_o);
endmodule

// File: rtl/ucmc_tiebreak.sv
module ucmc_tiebreak
  import ucmc_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 32,
  parameter int unsigned PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [PORT_W-1:0]  port_i,
  input  logic               both_i,
  input  logic               is_uc_i,
  input  logic               host_we_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [MASK_W-1:0]  host_wdata_i,
  output logic [MASK_W-1:0]  host_rdata_o,
  output logic               grant_valid_o,
  output logic               grant_uc_o
);
  localparam int unsigned IDX_W = $clog2(MASK_W);

  mask_t            mask_lo, mask_hi;
  logic [IDX_W-1:0] idx;
  logic             adv;

  ucmc_fair_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (host_we_i),
    .addr_i    (host_addr_i),
    .wdata_i   (host_wdata_i),
    .rdata_o   (host_rdata_o),
    .mask_lo_o (mask_lo),
    .mask_hi_o (mask_hi)
  );

  ucmc_idx_gen #(.IDX_W(IDX_W)) u_idx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .idx_o  (idx)
  );

  ucmc_decide #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .IDX_W     (IDX_W)
  ) u_decide (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .both_i        (both_i),
    .is_uc_i       (is_uc_i),
    .port_i        (port_i),
    .mask_lo_i     (mask_lo),
    .mask_hi_i     (mask_hi),
    .idx_i         (idx),
    .adv_o         (adv),
    .grant_valid_o (grant_valid_o),
    .grant_uc_o    (grant_uc_o)
  );
endmodule

// File: tb/ucmc_tiebreak_tb.sv
module ucmc_tiebreak_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [4:0] port_i = '0;
  logic       both_i = 1'b0;
  logic       is_uc_i = 1'b0;
  logic       host_we_i = 1'b0;
  logic [3:0] host_addr_i = '0;
  logic [7:0] host_wdata_i = '0;
  logic [7:0] host_rdata_o;
  logic       grant_valid_o, grant_uc_o;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  string cur_tag = "R1";

  // reference model
  int         seq [8] = '{1, 2, 5, 3, 7, 6, 4, 0};
  int         ptr = 0;
  logic [7:0] m_lo = 8'hA3, m_hi = 8'h3A;
  logic       e_gv = 1'b0, e_guc = 1'b0;
  logic       e_both = 1'b0;

  always #10 clk_i = ~clk_i;

  ucmc_tiebreak u_dut (.*);

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr = 0; m_lo = 8'hA3; m_hi = 8'h3A; e_gv = 0; e_guc = 0; e_both = 0;
    end else begin
      logic [7:0] m;
      m      = (port_i >= 16) ? m_hi : m_lo;
      e_gv   = req_valid_i;
      e_both = req_valid_i && both_i;
      if (!req_valid_i)  e_guc = 1'b0;
      else if (both_i) begin
        e_guc = m[seq[ptr]];
        ptr   = (ptr + 1) % 8;
      end else e_guc = is_uc_i;
      if (host_we_i && host_addr_i == 4'h9) m_lo = host_wdata_i;
      if (host_we_i && host_addr_i == 4'hA) m_hi = host_wdata_i;
    end
  end

  task automatic compare();
    logic [7:0] er;
    er = (host_addr_i == 4'h9) ? m_lo : (host_addr_i == 4'hA) ? m_hi : 8'h00;
    vectors++;
    if (grant_valid_o !== e_gv) begin
      errors++;
      $display("FAIL %s/R8 grant_valid got %b exp %b", cur_tag, grant_valid_o, e_gv);
    end
    if (grant_uc_o !== e_guc) begin
      errors++;
      $display("FAIL %s/%s grant_uc got %b exp %b", cur_tag, e_both ? "R5" : "R7",
               grant_uc_o, e_guc);
    end
    if (host_rdata_o !== er) begin
      errors++;
      $display("FAIL %s/R3 rdata@%h got %h exp %h", cur_tag, host_addr_i, host_rdata_o, er);
    end
  endtask

  task automatic cyc(input logic rq, input logic bo, input logic uc, input logic [4:0] pt,
                     input logic we, input logic [3:0] ad, input logic [7:0] wd);
    req_valid_i = rq; both_i = rq & bo; is_uc_i = rq & uc; port_i = pt;
    host_we_i = we; host_addr_i = ad; host_wdata_i = wd;
    @(negedge clk_i);
    compare();
  endtask

  task automatic wr(input logic [3:0] ad, input logic [7:0] wd);
    cyc(0, 0, 0, 0, 1, ad, wd);
  endtask

  // R9: n contended requests, count unicast wins
  task automatic window(input logic [4:0] pt, input int n, input int exp_wins);
    int wins = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1, 1, 0, pt, 0, 4'h9, 0);
      if (grant_uc_o === 1'b1) wins++;
    end
    vectors++;
    if (wins != exp_wins) begin
      errors++;
      $display("FAIL R9 port %0d uc wins got %0d exp %0d", pt, wins, exp_wins);
    end
  endtask

  initial begin
    @(negedge clk_i); @(negedge clk_i);
    // R1: reset state
    cur_tag = "R1";
    host_addr_i = 4'h9; #1 compare();
    host_addr_i = 4'hA; #1 compare();
    rst_ni = 1'b1;
    cyc(0, 0, 0, 0, 0, 4'h9, 0);
    // R1/R6: first contended decision uses index 1 (0xA3 bit1=1, 0x3A bit1=1)
    cur_tag = "R6";
    cyc(1, 1, 0, 5'd3, 0, 4'h9, 0);
    cyc(0, 0, 0, 0, 0, 4'h9, 0);
    cyc(0, 0, 0, 0, 0, 4'h9, 0);       // idle: no advance
    cyc(1, 1, 0, 5'd20, 0, 4'hA, 0);   // R4 upper half, index 2
    // R3: unmapped reads return zero
    cur_tag = "R3";
    for (int a = 0; a < 16; a++) cyc(0, 0, 0, 0, 0, 4'(a), 0);
    // R2: writes to other addresses ignored, byte writes independent
    cur_tag = "R2";
    wr(4'h5, 8'h55); wr(4'hB, 8'h77); wr(4'h8, 8'h11);
    cyc(0, 0, 0, 0, 0, 4'h9, 0); cyc(0, 0, 0, 0, 0, 4'hA, 0);
    wr(4'h9, 8'h00); cyc(0, 0, 0, 0, 0, 4'hA, 0);
    wr(4'hA, 8'hFF); cyc(0, 0, 0, 0, 0, 4'h9, 0);
    // R7: sole requester, masks irrelevant
    cur_tag = "R7";
    cyc(1, 0, 1, 5'd2, 0, 4'h9, 0); cyc(1, 0, 0, 5'd30, 0, 4'h9, 0);
    cyc(1, 0, 1, 5'd17, 0, 4'h9, 0); cyc(1, 0, 0, 5'd0, 0, 4'h9, 0);
    // R9 / R4: lower all zeros, upper all ones
    cur_tag = "R9";
    window(5'd15, 8, 0); window(5'd16, 8, 8); window(5'd0, 11, 0);
    wr(4'h9, 8'h0F); window(5'd7, 8, 4);
    wr(4'hA, 8'h3A); window(5'd31, 16, 8);
    wr(4'h9, 8'h01); window(5'd9, 8, 1);
    // R10: write in same cycle as contended request uses the old mask
    cur_tag = "R10";
    wr(4'h9, 8'h00);
    for (int i = 0; i < 8; i++) cyc(1, 1, 0, 5'd4, 1, 4'h9, (i % 2) ? 8'h00 : 8'hFF);
    // R5/R6 random mix
    cur_tag = "R5";
    for (int i = 0; i < 600; i++) begin
      int k = $urandom_range(0, 9);
      cyc(k > 2, k > 5, $urandom_range(0, 1), 5'($urandom_range(0, 31)),
          k < 3 || k == 9, 4'($urandom_range(8, 11)), 8'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end
endmodule